// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger Unit

This block takes the interrupt request of one PCI device and turns it into the single interrupt line that goes to the CPU. The device is identified by its slot number and by the pin it raises, INTA to INTD. The block maps that pair to an internal interrupt number. Internal numbers start at a base of 32. The line index used to look up configuration bits is the internal number minus that base.

The on-board slots have fixed lines. The south-bridge slot uses its pin directly. The graphics slot and the network slot each have a dedicated line. The expansion slots are rotated by slot and pin, so that devices in neighbouring slots spread over different lines.

Each line is configured by two 32-bit words. The edge word selects whether the line pulses the CPU output when its request rises. The polarity word sets the level the output takes on any change of a level-mode line. The request input is asynchronous and is passed through a synchronizer before any decision is made.

Top module: `pirq_router`

## Requirements
- R1: While reset is asserted, and directly after it, `cpu_irq` is low.
- R2: Pin values 0..3 stand for INTA..INTD. Slot 5 routes pin p to line p (internal number 32+p).
- R3: Slot 6 routes every pin to line 4. Slot 7 routes every pin to line 5.
- R4: Slots 8 to 12 route pin p to line (slot − 8 + p + 6), which gives lines 6 to 13.
- R5: Any other slot passes the raw pin number through as the internal number. That number lies below the base, so no line is selected. A request change from such a slot leaves `cpu_irq` unchanged.
- R6: A line is in edge mode when bit n of `edge_cfg` is 1, where n is the line index. In edge mode, a synchronized rising request drives `cpu_irq` high for exactly one clock cycle, after which it returns low.
- R7: In edge mode, a synchronized falling request leaves `cpu_irq` unchanged.
- R8: A line is in level mode when bit n of `edge_cfg` is 0. In level mode, any synchronized change of the request sets `cpu_irq` to bit n of `pol_cfg` (1 = high, 0 = low). The output then holds that value until the next event.
- R9: A request change that is first sampled at rising clock edge k shows on `cpu_irq` after edge k+2. After edge k+1 the output still holds its old value.
- R10: A change to `dev_slot`, `dev_pin`, `edge_cfg` or `pol_cfg` with no request change does not alter `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_slot | input | 5 | Slot number of the requesting device |
| dev_pin | input | 2 | Interrupt pin of the device, 0=INTA .. 3=INTD |
| irq_in | input | 1 | Asynchronous interrupt request of the device |
| edge_cfg | input | 32 | Per-line edge-mode select, bit n for line n |
| pol_cfg | input | 32 | Per-line level-mode output value, bit n for line n |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The assertions watch the trigger on every cycle:
- a qualifying rise is followed by a high output, which drops one cycle later;
- a level-mode event copies the selected polarity bit to the output;
- a cycle with no event on a selected line leaves the output untouched.

Whether the right line was selected for a given slot and pin only shows in the bench scenarios. The bench uses one-hot and inverted-one-hot polarity words, so a wrong route shows at the output. The two-cycle synchronizer latency is also checked only by the bench, which samples at fixed offsets after each request change.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    // Event seen on the synchronized request
    typedef enum logic [1:0] {
        EVT_IDLE = 2'd0,
        EVT_RISE = 2'd1,
        EVT_FALL = 2'd2
    } evt_e;

    // Output stage state
    typedef struct packed {
        logic out;
        logic pulse;
    } trig_st_t;

endpackage

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 2,
    parameter int ROUTE_W   = 7,
    parameter int IRQ_BASE  = 32,
    parameter int SB_SLOT   = 5,
    parameter int GFX_SLOT  = 6,
    parameter int GFX_LINE  = 4,
    parameter int NIC_SLOT  = 7,
    parameter int NIC_LINE  = 5,
    parameter int EXP_FIRST = 8,
    parameter int EXP_LAST  = 12,
    parameter int EXP_LINE  = 6
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic [PIN_W-1:0]   pin,
    output logic [ROUTE_W-1:0] route_num
);
    localparam int NUM_PINS = 1 << PIN_W;

    always_comb begin
        // Unknown slot: raw pin number, no translation
        route_num = ROUTE_W'(pin);
        if (slot == SLOT_W'(SB_SLOT)) begin
            route_num = ROUTE_W'(IRQ_BASE + (int'(pin) % NUM_PINS));
        end else if (slot == SLOT_W'(GFX_SLOT)) begin
            route_num = ROUTE_W'(IRQ_BASE + GFX_LINE);
        end else if (slot == SLOT_W'(NIC_SLOT)) begin
            route_num = ROUTE_W'(IRQ_BASE + NIC_LINE);
        end else if ((slot >= SLOT_W'(EXP_FIRST)) && (slot <= SLOT_W'(EXP_LAST))) begin
            route_num = ROUTE_W'(IRQ_BASE + EXP_LINE + int'(slot) - EXP_FIRST + int'(pin));
        end
    end

endmodule

// File: rtl/pirq_line_sel.sv
module pirq_line_sel #(
    parameter int ROUTE_W   = 7,
    parameter int IRQ_BASE  = 32,
    parameter int NUM_LINES = 32
) (
    input  logic [ROUTE_W-1:0]   route_num,
    input  logic [NUM_LINES-1:0] edge_cfg,
    input  logic [NUM_LINES-1:0] pol_cfg,
    output logic                 line_valid,
    output logic                 edge_bit,
    output logic                 pol_bit
);
    logic [NUM_LINES-1:0] hit;

    // One comparator per line; a number outside the window hits nothing
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign hit[i] = (route_num == ROUTE_W'(IRQ_BASE + i));
    end

    assign line_valid = |hit;
    assign edge_bit   = |(hit & edge_cfg);
    assign pol_bit    = |(hit & pol_cfg);

endmodule

// File: rtl/pirq_sync.sv
module pirq_sync
    import pirq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output evt_e evt
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];

        evt = EVT_IDLE;
        if (st_q.chain[STAGES-1] && !st_q.prev) begin
            evt = EVT_RISE;
        end else if (!st_q.chain[STAGES-1] && st_q.prev) begin
            evt = EVT_FALL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pirq_trigger.sv
module pirq_trigger
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_e evt,
    input  logic line_valid,
    input  logic edge_bit,
    input  logic pol_bit,
    output logic cpu_irq
);
    trig_st_t st_d, st_q;

    always_comb begin
        st_d.pulse = 1'b0;
        st_d.out   = st_q.pulse ? 1'b0 : st_q.out;
        if (line_valid && (evt != EVT_IDLE)) begin
            if (edge_bit) begin
                if (evt == EVT_RISE) begin
                    st_d.out   = 1'b1;
                    st_d.pulse = 1'b1;
                end
            end else begin
                st_d.out = pol_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_irq = st_q.out;

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int SLOT_W      = 5,
    parameter int PIN_W       = 2,
    parameter int NUM_LINES   = 32,
    parameter int IRQ_BASE    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_W-1:0]    dev_slot,
    input  logic [PIN_W-1:0]     dev_pin,
    input  logic                 irq_in,
    input  logic [NUM_LINES-1:0] edge_cfg,
    input  logic [NUM_LINES-1:0] pol_cfg,
    output logic                 cpu_irq
);
    localparam int ROUTE_W = $clog2(IRQ_BASE + NUM_LINES + 1) + 1;

    logic [ROUTE_W-1:0] route_num_w;
    logic               line_valid_w;
    logic               edge_bit_w;
    logic               pol_bit_w;
    evt_e               evt_w;

    pirq_slot_map #(
        .SLOT_W   (SLOT_W),
        .PIN_W    (PIN_W),
        .ROUTE_W  (ROUTE_W),
        .IRQ_BASE (IRQ_BASE)
    ) i_slot_map (
        .slot      (dev_slot),
        .pin       (dev_pin),
        .route_num (route_num_w)
    );

    pirq_line_sel #(
        .ROUTE_W   (ROUTE_W),
        .IRQ_BASE  (IRQ_BASE),
        .NUM_LINES (NUM_LINES)
    ) i_line_sel (
        .route_num  (route_num_w),
        .edge_cfg   (edge_cfg),
        .pol_cfg    (pol_cfg),
        .line_valid (line_valid_w),
        .edge_bit   (edge_bit_w),
        .pol_bit    (pol_bit_w)
    );

    pirq_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .evt   (evt_w)
    );

    pirq_trigger i_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_w),
        .line_valid (line_valid_w),
        .edge_bit   (edge_bit_w),
        .pol_bit    (pol_bit_w),
        .cpu_irq    (cpu_irq)
    );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input evt_e evt,
    input logic line_valid,
    input logic edge_bit,
    input logic pol_bit,
    input logic cpu_irq
);
    logic pulse_seen;
    logic any_evt;

    assign any_evt = (evt != EVT_IDLE) && line_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_seen <= 1'b0;
        end else begin
            pulse_seen <= (evt == EVT_RISE) && line_valid && edge_bit;
        end
    end

    // R1: output low while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r1: assert (!cpu_irq);
        end
    end

    p_edge_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt == EVT_RISE) && line_valid && edge_bit) |=> cpu_irq);

    p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_seen && !any_evt) |=> !cpu_irq);

    p_edge_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt == EVT_FALL) && line_valid && edge_bit && !pulse_seen) |=> $stable(cpu_irq));

    p_level_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_evt && !edge_bit) |=> (cpu_irq == $past(pol_bit)));

    p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt != EVT_IDLE) && !line_valid && !pulse_seen) |=> $stable(cpu_irq));

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !pulse_seen) |=> $stable(cpu_irq));

endmodule

bind pirq_router pirq_router_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_w),
    .line_valid (line_valid_w),
    .edge_bit   (edge_bit_w),
    .pol_bit    (pol_bit_w),
    .cpu_irq    (cpu_irq)
);

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dev_slot = '0;
    logic [1:0]  dev_pin = '0;
    logic        irq_in = 1'b0;
    logic [31:0] edge_cfg = '0;
    logic [31:0] pol_cfg = '0;
    logic        cpu_irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  exp_out = 1'b0;

    always #2 clk = ~clk;

    pirq_router i_pirq_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_slot (dev_slot),
        .dev_pin  (dev_pin),
        .irq_in   (irq_in),
        .edge_cfg (edge_cfg),
        .pol_cfg  (pol_cfg),
        .cpu_irq  (cpu_irq)
    );

    function automatic int exp_line(int s, int p);
        if (s == 5) return p % 4;
        if (s == 6) return 4;
        if (s == 7) return 5;
        if (s >= 8 && s <= 12) return s - 8 + p + 6;
        return -1;
    endfunction

    task automatic check(bit act, bit exp, string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: cpu_irq=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Toggle the request with the given routing/config and check the response
    task automatic do_event(int s, int p, logic [31:0] ecfg, logic [31:0] pcfg, string req);
        int  ln;
        bit  rising, pulse, nxt;
        @(negedge clk);
        dev_slot = 5'(s);
        dev_pin  = 2'(p);
        edge_cfg = ecfg;
        pol_cfg  = pcfg;
        irq_in   = ~irq_in;
        rising   = irq_in;
        ln    = exp_line(s, p);
        pulse = 1'b0;
        nxt   = exp_out;
        if (ln >= 0 && ln < 32) begin
            if (ecfg[ln]) begin
                if (rising) begin
                    pulse = 1'b1;
                    nxt   = 1'b0;
                end
            end else begin
                nxt = pcfg[ln];
            end
        end
        @(negedge clk);
        @(negedge clk);
        check(cpu_irq, exp_out, "R9");
        @(negedge clk);
        check(cpu_irq, pulse ? 1'b1 : nxt, req);
        @(negedge clk);
        check(cpu_irq, nxt, req);
        exp_out = nxt;
    endtask

    task automatic map_check(int s, int p, string req);
        int ln = exp_line(s, p);
        do_event(s, p, 32'h0, 32'h1 << ln, req);
        do_event(s, p, 32'h0, ~(32'h1 << ln), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd13579));
        repeat (3) @(negedge clk);
        check(cpu_irq, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_irq, 1'b0, "R1");

        // R2: south-bridge slot
        for (int p = 0; p < 4; p++) map_check(5, p, "R2");
        // R3: fixed slots, any pin
        for (int p = 0; p < 4; p++) map_check(6, p, "R3");
        for (int p = 0; p < 4; p++) map_check(7, p, "R3");
        // R4: expansion slots
        for (int s = 8; s <= 12; s++)
            for (int p = 0; p < 4; p++) map_check(s, p, "R4");

        // R6 / R7: edge mode on line 5
        if (irq_in) do_event(7, 0, 32'h0, 32'h0, "R8");
        do_event(7, 2, 32'h1 << 5, 32'h0, "R6");
        do_event(7, 2, 32'h1 << 5, 32'h0, "R7");
        do_event(7, 2, 32'h0, 32'h1 << 5, "R8");
        do_event(7, 2, 32'h1 << 5, 32'h0, "R7");
        do_event(7, 2, 32'h1 << 5, 32'h0, "R6");

        // R5: unmapped slots never move the output
        do_event(5, 1, 32'h0, 32'hFFFF_FFFF, "R8");
        do_event(0, 3, 32'h0, 32'h0, "R5");
        do_event(31, 0, 32'hFFFF_FFFF, 32'h0, "R5");
        do_event(5, 1, 32'h0, 32'h0, "R8");
        do_event(13, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
        do_event(4, 1, 32'h0, 32'hFFFF_FFFF, "R5");

        // R10: routing/config changes with a steady request
        do_event(9, 1, 32'h0, 32'hFFFF_FFFF, "R8");
        @(negedge clk);
        dev_slot = 5'd6; dev_pin = 2'd3; pol_cfg = 32'h0; edge_cfg = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        check(cpu_irq, exp_out, "R10");
        dev_slot = 5'd11; pol_cfg = 32'h0; edge_cfg = 32'h0;
        repeat (4) @(negedge clk);
        check(cpu_irq, exp_out, "R10");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int s, p;
            logic [31:0] e, q;
            s = ($urandom % 3 == 0) ? int'($urandom % 32) : 5 + int'($urandom % 8);
            p = int'($urandom % 4);
            e = $urandom;
            q = $urandom;
            do_event(s, p, e, q, "R8");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule